// File: doc/BRIEF.md
# Serial Word Transmitter with Return-to-Zero Line Output

This block takes 32-bit words from a host that writes them as two 16-bit halves, queues them in a 32-entry FIFO, and sends them one bit at a time on a pair of logic-level line outputs. Each bit uses three line levels. A bit time starts with a high phase on one of the two outputs: `line_a` for a one, `line_b` for a zero. A null phase with both outputs low follows. External driver circuitry turns this pair into bus voltages.

The host writes the lower half first. The upper-half strobe completes the word and pushes it into the FIFO. An option chosen at that strobe replaces bit 32 with a generated odd-parity bit. While the transmit enable is high, the block takes words from the FIFO one at a time. It sends each word bit 1 first and leaves a quiet gap of four bit times after it. The phase length is a whole number of reference-clock cycles. The value depends on a rate select, which the block samples at the start of each word.

Top module: `swtx_top`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_half` and `fifo_full` are 0, `tx_ready` is 1, and both line outputs are 0.
- R2: The FIFO holds up to 32 words. `fifo_empty` means 0 words are stored, `fifo_half` means 16 or more are stored, and `fifo_full` means 32 are stored.
- R3: A `load_lo` strobe stores `host_data` as word bits 16..1, with `host_data[0]` as bit 1. A `load_hi` strobe supplies bits 32..17 from `host_data` and pushes the assembled word into the FIFO in that same clock edge.
- R4: If `par_en` is 1 when `load_hi` is applied, bit 32 of the stored word is replaced so that the full 32-bit word has an odd number of ones. If `par_en` is 0, bit 32 is `host_data[15]`.
- R5: Each bit lasts 2·P clock cycles. For the first P cycles, `line_a` is 1 for a one bit, or `line_b` is 1 for a zero bit. For the last P cycles, both outputs are 0.
- R6: A word starts at a clock edge where the transmitter is idle, `tx_en` is 1 and the FIFO is not empty. Bit 1 appears in the next cycle, and the bits follow in order through bit 32.
- R7: While `tx_en` is 0, no new word starts. A word already in progress, including its gap, runs to completion.
- R8: After bit 32, both outputs stay 0 for 8·P cycles, which is four bit times. The next word can start at the edge that follows this gap.
- R9: `tx_ready` is 1 exactly when the FIFO is empty and no word or gap is in progress.
- R10: A `load_hi` or `load_lo` strobe applied while `fifo_full` is 1 changes neither the FIFO contents nor the stored lower half.
- R11: P equals PHASE_FAST when `rate_sel` is 0 and PHASE_SLOW when it is 1. The block samples `rate_sel` at the start edge of each word and holds the value for that word and its gap.
- R12: `line_a` and `line_b` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Host half-word bus |
| load_lo | input | 1 | Strobe that stores the lower half-word |
| load_hi | input | 1 | Strobe that supplies the upper half-word and pushes the word |
| par_en | input | 1 | Replace bit 32 with odd parity, sampled with `load_hi` |
| tx_en | input | 1 | Allow new words to start |
| rate_sel | input | 1 | Phase length select: 0 for fast, 1 for slow |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_half | output | 1 | FIFO holds 16 or more words |
| fifo_full | output | 1 | FIFO holds 32 words |
| tx_ready | output | 1 | FIFO empty and transmitter idle |
| line_a | output | 1 | High phase of one bits |
| line_b | output | 1 | High phase of zero bits |

## Verification
The assertions assume that the host never asserts `load_lo` and `load_hi` in the same cycle. They also assume that the strobes and `tx_en` change only between clock edges, so each strobe covers exactly one rising edge. The stimulus drives every input on the falling edge and pulses each strobe for one cycle. It loads words while the line is busy, fills the FIFO past its capacity with transmission held off, drops the enable in the middle of a word, and changes `rate_sel` during a word. These cases test the sampling and the ignore rules without breaking the assumptions.

// File: rtl/swtx_pkg.sv
package swtx_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int GAP_PHASES = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic [HALF_W-1:0] lower;
    } word_t;

    function automatic word_t set_odd_parity(input word_t w);
        logic [WORD_W-1:0] flat;
        flat = w;
        flat[WORD_W-1] = ~^flat[WORD_W-2:0];
        return word_t'(flat);
    endfunction
endpackage

// File: rtl/swtx_loader.sv
module swtx_loader
    import swtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] host_data,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              par_en,
    input  logic              fifo_full,
    output logic              push,
    output word_t             push_word
);
    logic [HALF_W-1:0] lower_q;
    word_t             raw_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            lower_q <= '0;
        end else if (load_lo && !fifo_full) begin
            lower_q <= host_data;
        end
    end

    always_comb begin
        raw_word.upper = host_data;
        raw_word.lower = lower_q;
        push_word      = par_en ? set_odd_parity(raw_word) : raw_word;
        push           = load_hi && !fifo_full;
    end
endmodule

// File: rtl/swtx_fifo.sv
module swtx_fifo
    import swtx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  word_t push_word,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  half,
    output logic  full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

    word_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push;
    logic           do_pop;

    assign do_push = push && (count != CNT_FULL);
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign half  = (count >= CNT_HALF);
    assign full  = (count == CNT_FULL);
endmodule

// File: rtl/swtx_shifter.sv
module swtx_shifter
    import swtx_pkg::*;
#(
    parameter int PHASE_FAST = 5,
    parameter int PHASE_SLOW = 40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_en,
    input  logic  rate_sel,
    input  logic  fifo_empty,
    input  word_t head,
    output logic  pop,
    output logic  idle,
    output logic  line_a,
    output logic  line_b
);
    localparam int MAXP = (PHASE_SLOW > PHASE_FAST) ? PHASE_SLOW : PHASE_FAST;
    localparam int CW   = $clog2(MAXP + 1);
    localparam int BW   = $clog2(WORD_W);
    localparam int GW   = $clog2(GAP_PHASES);
    localparam logic [CW-1:0] LEN_FAST = CW'(PHASE_FAST);
    localparam logic [CW-1:0] LEN_SLOW = CW'(PHASE_SLOW);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
    localparam logic [GW-1:0] LAST_GAP = GW'(GAP_PHASES - 1);

    tx_state_e          state;
    logic [WORD_W-1:0]  shreg;
    logic [BW-1:0]      bit_idx;
    logic [GW-1:0]      gap_idx;
    logic               phase_hi;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      phase_len;
    logic               phase_end;

    assign pop       = (state == ST_IDLE) && tx_en && !fifo_empty;
    assign phase_end = (cnt == phase_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bit_idx   <= '0;
            gap_idx   <= '0;
            phase_hi  <= 1'b0;
            cnt       <= '0;
            phase_len <= LEN_FAST;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pop) begin
                        state     <= ST_SEND;
                        shreg     <= head;
                        bit_idx   <= '0;
                        phase_hi  <= 1'b1;
                        cnt       <= '0;
                        phase_len <= rate_sel ? LEN_SLOW : LEN_FAST;
                    end
                end
                ST_SEND: begin
                    if (phase_end) begin
                        cnt <= '0;
                        if (phase_hi) begin
                            phase_hi <= 1'b0;
                        end else begin
                            phase_hi <= 1'b1;
                            shreg    <= shreg >> 1;
                            if (bit_idx == LAST_BIT) begin
                                state   <= ST_GAP;
                                gap_idx <= '0;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (phase_end) begin
                        cnt <= '0;
                        if (gap_idx == LAST_GAP) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_idx <= gap_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idle   = (state == ST_IDLE);
    assign line_a = (state == ST_SEND) && phase_hi && shreg[0];
    assign line_b = (state == ST_SEND) && phase_hi && !shreg[0];
endmodule

// File: rtl/swtx_top.sv
module swtx_top
    import swtx_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int PHASE_FAST = 5,
    parameter int PHASE_SLOW = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] host_data,
    input  logic        load_lo,
    input  logic        load_hi,
    input  logic        par_en,
    input  logic        tx_en,
    input  logic        rate_sel,
    output logic        fifo_empty,
    output logic        fifo_half,
    output logic        fifo_full,
    output logic        tx_ready,
    output logic        line_a,
    output logic        line_b
);
    logic  fifo_push;
    logic  fifo_pop;
    logic  tx_idle;
    word_t push_word;
    word_t head_word;

    swtx_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .host_data (host_data),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .par_en    (par_en),
        .fifo_full (fifo_full),
        .push      (fifo_push),
        .push_word (push_word)
    );

    swtx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_word (push_word),
        .pop       (fifo_pop),
        .head      (head_word),
        .empty     (fifo_empty),
        .half      (fifo_half),
        .full      (fifo_full)
    );

    swtx_shifter #(.PHASE_FAST(PHASE_FAST), .PHASE_SLOW(PHASE_SLOW)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .rate_sel   (rate_sel),
        .fifo_empty (fifo_empty),
        .head       (head_word),
        .pop        (fifo_pop),
        .idle       (tx_idle),
        .line_a     (line_a),
        .line_b     (line_b)
    );

    assign tx_ready = fifo_empty && tx_idle;
endmodule

// File: rtl/swtx_checker.sv
module swtx_checker (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic load_hi,
    input logic fifo_empty,
    input logic fifo_half,
    input logic fifo_full,
    input logic fifo_pop,
    input logic tx_ready,
    input logic line_a,
    input logic line_b
);
    p_lines_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        !(line_a && line_b));

    p_full_implies_half_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> (fifo_half && !fifo_empty));

    p_no_pop_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_pop);

    p_ready_means_empty_r9: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (fifo_empty && !line_a && !line_b));

    p_hold_when_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_en) |=> (!line_a && !line_b));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && load_hi && !fifo_pop) |=> fifo_full);
endmodule

bind swtx_top swtx_checker u_chk (.*);

// File: tb/swtx_top_tb.sv
module swtx_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PF = 2;
    localparam int PS = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_data = '0;
    logic        load_lo = 1'b0;
    logic        load_hi = 1'b0;
    logic        par_en = 1'b0;
    logic        tx_en = 1'b0;
    logic        rate_sel = 1'b0;
    logic        fifo_empty, fifo_half, fifo_full, tx_ready, line_a, line_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swtx_top #(.DEPTH(32), .PHASE_FAST(PF), .PHASE_SLOW(PS)) u_dut (
        .clk(clk), .rst(rst), .host_data(host_data), .load_lo(load_lo),
        .load_hi(load_hi), .par_en(par_en), .tx_en(tx_en), .rate_sel(rate_sel),
        .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_full(fifo_full),
        .tx_ready(tx_ready), .line_a(line_a), .line_b(line_b)
    );

    // behavioural reference model
    logic [31:0] q[$];
    logic [15:0] m_lo;
    bit          m_busy;
    int          m_e;
    int          m_p;
    logic [31:0] m_cur;

    function automatic logic [31:0] make_word(logic [15:0] hi, logic [15:0] lo, logic par);
        logic [31:0] w;
        int ones;
        w = {hi, lo};
        if (par) begin
            ones = 0;
            for (int i = 0; i < 31; i++) ones += w[i];
            w[31] = (ones % 2 == 0);  // R4: odd count overall
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_lo = '0; m_busy = 0; m_e = 0; m_p = PF; m_cur = '0;
        end else begin
            int  sz;
            bit  start;
            sz    = q.size();
            start = !m_busy && tx_en && (sz > 0);       // R6, R7
            if (m_busy) begin
                if (m_e == 72*m_p - 1) m_busy = 0;      // R8
                else m_e++;
            end
            if (start) begin
                m_cur = q.pop_front();
                m_busy = 1; m_e = 0;
                m_p = rate_sel ? PS : PF;               // R11
            end
            if (load_hi && sz < 32) q.push_back(make_word(host_data, m_lo, par_en)); // R3, R10
            if (load_lo && sz < 32) m_lo = host_data;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic ea, eb;
            int   sz;
            sz = q.size();
            ea = 0; eb = 0;
            if (m_busy && m_e < 64*m_p && (m_e % (2*m_p)) < m_p) begin
                ea = m_cur[m_e/(2*m_p)];               // R5, R6
                eb = !m_cur[m_e/(2*m_p)];
            end
            check("R5 line_a", {31'd0, line_a}, {31'd0, ea});
            check("R5 line_b", {31'd0, line_b}, {31'd0, eb});
            check("R2 flags", {29'd0, fifo_empty, fifo_half, fifo_full},
                  {29'd0, sz == 0, sz >= 16, sz == 32});
            check("R9 tx_ready", {31'd0, tx_ready}, {31'd0, (sz == 0) && !m_busy});
            check("R12 exclusive", {31'd0, line_a & line_b}, 32'd0);
        end
    end

    task automatic load_word(logic [31:0] w, logic par);
        @(negedge clk);
        host_data = w[15:0]; load_lo = 1; par_en = par;
        @(negedge clk);
        load_lo = 0; host_data = w[31:16]; load_hi = 1;
        @(negedge clk);
        load_hi = 0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (tx_ready && !m_busy) break;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", {26'd0, fifo_empty, fifo_half, fifo_full, tx_ready, line_a, line_b},
              {26'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

        // R3, R4, R7: load while disabled, lines stay quiet
        load_word(32'h8000_0001, 1'b0);
        load_word(32'h0000_0003, 1'b1);
        load_word(32'h8000_0003, 1'b1);
        repeat (20) @(negedge clk);
        check("R7 idle while disabled", {31'd0, line_a | line_b}, 32'd0);

        // R6, R8, R5: fast rate transmission
        tx_en = 1;
        load_word(32'hA5C3_0FF0, 1'b0);
        wait_ready();

        // R11: slow rate, rate_sel changed mid-word
        rate_sel = 1;
        load_word(32'h1234_5678, 1'b1);
        repeat (30) @(negedge clk);
        rate_sel = 0;
        load_word(32'hFFFF_FFFF, 1'b0);
        wait_ready();

        // R7: drop enable mid-word, word completes, next held
        load_word(32'h0F0F_F0F0, 1'b0);
        load_word(32'h5555_AAAA, 1'b1);
        repeat (10) @(negedge clk);
        tx_en = 0;
        repeat (400) @(negedge clk);
        check("R7 held word", {31'd0, fifo_empty}, 32'd0);

        // R2, R10: fill FIFO, overload, then drain
        for (int i = 0; i < 34; i++) load_word(32'h0101_0101 * (i + 3) ^ 32'hC0DE_0000, i[0]);
        check("R2 full", {31'd0, fifo_full}, 32'd1);
        load_lo = 1; host_data = 16'hDEAD;
        @(negedge clk);
        load_lo = 0;
        check("R10 still full", {31'd0, fifo_full}, 32'd1);
        tx_en = 1;
        wait_ready();
        check("R9 drained", {31'd0, tx_ready}, 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule